// File: doc/BRIEF.md
# Auxiliary Serial Audio Input with Output Routing

This block accepts a second stereo serial audio stream that has its own bit clock, frame clock and data line. It deserialises 20-bit two's-complement samples, most significant bit first. The left and right samples of each frame are joined into a pair, and the pair is carried into the system clock domain through a small dual-clock pair buffer with Gray-coded pointers. The auxiliary frame rate must match the system frame rate, but the two frame clocks may have any phase relationship.

In the system domain the block generates the main frame clock and drives two serial outputs, one bit per system clock. A two-bit route select chooses what each output carries. The outputs can carry converter capture samples presented in parallel, the buffered auxiliary pair, or silence. The reader waits until two pairs are buffered and then takes exactly one pair per main frame. This gives a latency of about two frames. When the buffer runs dry, the last pair is repeated. When the buffer runs too full, the oldest pair is discarded. Each of these events sets a flag that stays set until reset.

Top module: `aux_audio_router`

## Requirements
- R1: An auxiliary sample starts on the aux bit clock rising edge where `aux_lrck` differs from its value at the previous edge. That edge supplies bit 19. The next 19 edges supply the remaining bits in falling order. Further bits in the slot are ignored. A slot with `aux_lrck` low is left and a slot with it high is right. A pair is buffered when its right sample completes.
- R2: `main_lrck` is low for MAIN_SLOT (32) system clocks and then high for MAIN_SLOT clocks, repeating. It is low in the first cycle after reset.
- R3: Each output slot carries a 20-bit sample, MSB first, starting in the slot's first cycle. The remaining MAIN_SLOT-20 bits of the slot are zero. The left sample goes in the low half of the frame and the right sample in the high half.
- R4: With `route_sel` equal to 0 or 3, both `sdout1` and `sdout2` carry `adc_left` and `adc_right`, sampled at the frame boundary.
- R5: With `route_sel` equal to 1, `sdout1` carries the buffered auxiliary pair and `sdout2` is all zeros.
- R6: With `route_sel` equal to 2, `sdout1` carries the buffered auxiliary pair and `sdout2` carries the converter pair.
- R7: Until two pairs are buffered, the auxiliary pair is zero. After that, with equal frame rates, each main frame carries the next consecutive auxiliary pair, 1 to 3 pairs behind the newest pair driven on the aux input.
- R8: If no pair is buffered at a frame boundary, the previous auxiliary pair is repeated and `underflow_flag` is set.
- R9: If FIFO_DEPTH-1 (3) or more pairs are buffered at a frame boundary, the oldest pair is discarded, the next pair is used, and `overflow_flag` is set.
- R10: After reset, both outputs and both flags are 0. Once set, a flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one main-port bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| aux_bclk | input | 1 | Auxiliary bit clock, data sampled on rising edge |
| aux_lrck | input | 1 | Auxiliary frame clock, low = left slot |
| aux_data | input | 1 | Auxiliary serial data |
| adc_left | input | 20 | Converter left sample, two's complement |
| adc_right | input | 20 | Converter right sample, two's complement |
| route_sel | input | 2 | Output routing select |
| main_lrck | output | 1 | Main frame clock, low = left slot |
| sdout1 | output | 1 | First serial output |
| sdout2 | output | 1 | Second serial output |
| underflow_flag | output | 1 | Sticky: pair repeated for lack of data |
| overflow_flag | output | 1 | Sticky: oldest pair discarded |

## Verification
An error in a buffer pointer or in its synchronisation shows up within one or two frames on `sdout1`. The decoded pair index then skips or repeats while the frame rates are equal, or its distance from the newest driven pair leaves the 1 to 3 window. A wrong deserialiser bit count corrupts the right sample, so the pair no longer satisfies the bench's index-to-value relation. A fault in the framing counter breaks the zero padding or the frame clock period on the very next slot. Rate-skew phases push the buffer into both starvation and excess, and show the repeat and the discard in the index sequence together with the flags.

// File: rtl/aux_route_pkg.sv
package aux_route_pkg;
   typedef enum logic [1:0] {
      ROUTE_ADC_BOTH = 2'd0,
      ROUTE_AUX_MUTE = 2'd1,
      ROUTE_AUX_ADC  = 2'd2,
      ROUTE_ADC_ALT  = 2'd3
   } route_e;
endpackage

// File: rtl/aux_rx_deser.sv
module aux_rx_deser #(
   parameter int W = 20
) (
   input  logic           bclk,
   input  logic           rst_n,
   input  logic           lrck,
   input  logic           data,
   output logic           wr_en,
   output logic [2*W-1:0] wr_pair
);
   localparam int CW = $clog2(W + 1);

   logic          lrck_q;
   logic [CW-1:0] got;
   logic [W-1:0]  shreg;
   logic [W-1:0]  left_hold;
   logic          left_ok;

   logic          slot_edge;
   logic          active;
   logic [CW-1:0] bit_idx;
   logic [W-1:0]  word_next;
   logic          last_bit;

   always_comb begin
      slot_edge = (lrck != lrck_q);
      bit_idx   = slot_edge ? '0 : got;
      active    = slot_edge || (got < CW'(W));
      word_next = slot_edge ? {{(W-1){1'b0}}, data} : {shreg[W-2:0], data};
      last_bit  = active && (bit_idx == CW'(W - 1));
   end

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         lrck_q    <= 1'b1;
         got       <= CW'(W);
         shreg     <= '0;
         left_hold <= '0;
         left_ok   <= 1'b0;
         wr_en     <= 1'b0;
         wr_pair   <= '0;
      end else begin
         lrck_q <= lrck;
         wr_en  <= 1'b0;
         if (active) begin
            shreg <= word_next;
            got   <= bit_idx + CW'(1);
         end
         if (last_bit) begin
            if (!lrck) begin
               left_hold <= word_next;
               left_ok   <= 1'b1;
            end else if (left_ok) begin
               wr_en   <= 1'b1;
               wr_pair <= {left_hold, word_next};
               left_ok <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/aux_pair_fifo.sv
module aux_pair_fifo #(
   parameter int DW    = 40,
   parameter int DEPTH = 4,
   parameter int SYNC  = 2
) (
   input  logic                     wclk,
   input  logic                     rclk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [DW-1:0]            wr_data,
   input  logic                     rd_pop,
   input  logic                     rd_skip,
   output logic [DW-1:0]            rd_head,
   output logic [DW-1:0]            rd_next,
   output logic [$clog2(DEPTH):0]   rd_level
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("aux_pair_fifo: DEPTH must be a power of two, at least 4");
   end
   if (SYNC < 2) begin : g_bad_sync
      $error("aux_pair_fifo: SYNC must be at least 2");
   end

   function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [DW-1:0] mem [DEPTH];

   // write side
   logic [PW-1:0] wbin, wgray;
   logic [PW-1:0] r2w [SYNC];
   logic [PW-1:0] wlevel;
   logic          do_write;

   assign wlevel   = wbin - from_gray(r2w[SYNC-1]);
   assign do_write = wr_en && (wlevel != PW'(DEPTH));

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
         for (int i = 0; i < SYNC; i++) r2w[i] <= '0;
      end else begin
         r2w[0] <= rgray;
         for (int i = 1; i < SYNC; i++) r2w[i] <= r2w[i-1];
         if (do_write) begin
            wbin  <= wbin + PW'(1);
            wgray <= to_gray(wbin + PW'(1));
         end
      end
   end

   always_ff @(posedge wclk) begin
      if (do_write) mem[wbin[AW-1:0]] <= wr_data;
   end

   // read side
   logic [PW-1:0] rbin, rgray;
   logic [PW-1:0] w2r [SYNC];
   logic [PW-1:0] radv;

   assign radv = !rd_pop ? '0 : (rd_skip ? PW'(2) : PW'(1));

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rbin  <= '0;
         rgray <= '0;
         for (int i = 0; i < SYNC; i++) w2r[i] <= '0;
      end else begin
         w2r[0] <= wgray;
         for (int i = 1; i < SYNC; i++) w2r[i] <= w2r[i-1];
         rbin  <= rbin + radv;
         rgray <= to_gray(rbin + radv);
      end
   end

   assign rd_level = from_gray(w2r[SYNC-1]) - rbin;
   assign rd_head  = mem[rbin[AW-1:0]];
   assign rd_next  = mem[rbin[AW-1:0] + AW'(1)];
endmodule

// File: rtl/main_frame_tx.sv
module main_frame_tx
   import aux_route_pkg::*;
#(
   parameter int W     = 20,
   parameter int SLOT  = 32,
   parameter int DEPTH = 4,
   parameter int PRIME = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [W-1:0]           adc_left,
   input  logic [W-1:0]           adc_right,
   input  logic [1:0]             route_sel,
   input  logic [2*W-1:0]         rd_head,
   input  logic [2*W-1:0]         rd_next,
   input  logic [$clog2(DEPTH):0] rd_level,
   output logic                   rd_pop,
   output logic                   rd_skip,
   output logic                   main_lrck,
   output logic                   sdout1,
   output logic                   sdout2,
   output logic                   underflow_flag,
   output logic                   overflow_flag
);
   localparam int FW = 2 * SLOT;
   localparam int CW = $clog2(FW);
   localparam int LW = $clog2(DEPTH) + 1;

   logic [CW-1:0]  cnt;
   logic [FW-1:0]  sh1, sh2;
   logic [2*W-1:0] held;
   logic           primed;

   logic           frame_end;
   logic [2*W-1:0] aux_pick;
   logic           uf_now, of_now, prime_now;
   logic [FW-1:0]  word_aux, word_adc, word1, word2;

   assign frame_end = (cnt == CW'(FW - 1));

   always_comb begin
      rd_pop    = 1'b0;
      rd_skip   = 1'b0;
      aux_pick  = held;
      uf_now    = 1'b0;
      of_now    = 1'b0;
      prime_now = 1'b0;
      if (frame_end) begin
         if (!primed) begin
            if (rd_level >= LW'(PRIME)) begin
               rd_pop    = 1'b1;
               aux_pick  = rd_head;
               prime_now = 1'b1;
            end
         end else if (rd_level == '0) begin
            uf_now = 1'b1;
         end else if (rd_level >= LW'(DEPTH - 1)) begin
            rd_pop   = 1'b1;
            rd_skip  = 1'b1;
            aux_pick = rd_next;
            of_now   = 1'b1;
         end else begin
            rd_pop   = 1'b1;
            aux_pick = rd_head;
         end
      end
   end

   if (SLOT == W) begin : g_tight
      assign word_aux = {aux_pick[2*W-1:W], aux_pick[W-1:0]};
      assign word_adc = {adc_left, adc_right};
   end else begin : g_padded
      localparam int PADW = SLOT - W;
      assign word_aux = {aux_pick[2*W-1:W], {PADW{1'b0}}, aux_pick[W-1:0], {PADW{1'b0}}};
      assign word_adc = {adc_left, {PADW{1'b0}}, adc_right, {PADW{1'b0}}};
   end

   always_comb begin
      case (route_e'(route_sel))
         ROUTE_AUX_MUTE: begin word1 = word_aux; word2 = '0;       end
         ROUTE_AUX_ADC:  begin word1 = word_aux; word2 = word_adc; end
         default:        begin word1 = word_adc; word2 = word_adc; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt            <= '0;
         sh1            <= '0;
         sh2            <= '0;
         held           <= '0;
         primed         <= 1'b0;
         underflow_flag <= 1'b0;
         overflow_flag  <= 1'b0;
      end else if (frame_end) begin
         cnt            <= '0;
         sh1            <= word1;
         sh2            <= word2;
         held           <= aux_pick;
         primed         <= primed | prime_now;
         underflow_flag <= underflow_flag | uf_now;
         overflow_flag  <= overflow_flag | of_now;
      end else begin
         cnt <= cnt + CW'(1);
         sh1 <= {sh1[FW-2:0], 1'b0};
         sh2 <= {sh2[FW-2:0], 1'b0};
      end
   end

   assign main_lrck = (cnt >= CW'(SLOT));
   assign sdout1    = sh1[FW-1];
   assign sdout2    = sh2[FW-1];
endmodule

// File: rtl/aux_audio_router.sv
module aux_audio_router #(
   parameter int SAMPLE_W    = 20,
   parameter int MAIN_SLOT   = 32,
   parameter int FIFO_DEPTH  = 4,
   parameter int PRIME_LEVEL = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                aux_bclk,
   input  logic                aux_lrck,
   input  logic                aux_data,
   input  logic [SAMPLE_W-1:0] adc_left,
   input  logic [SAMPLE_W-1:0] adc_right,
   input  logic [1:0]          route_sel,
   output logic                main_lrck,
   output logic                sdout1,
   output logic                sdout2,
   output logic                underflow_flag,
   output logic                overflow_flag
);
   localparam int PAIR_W = 2 * SAMPLE_W;
   localparam int LVL_W  = $clog2(FIFO_DEPTH) + 1;

   if (SAMPLE_W < 2) begin : g_bad_w
      $error("aux_audio_router: SAMPLE_W must be at least 2");
   end
   if (MAIN_SLOT < SAMPLE_W) begin : g_bad_slot
      $error("aux_audio_router: MAIN_SLOT must hold a whole sample");
   end
   if (PRIME_LEVEL < 1 || PRIME_LEVEL >= FIFO_DEPTH - 1) begin : g_bad_prime
      $error("aux_audio_router: PRIME_LEVEL must lie in 1..FIFO_DEPTH-2");
   end

   logic              wr_en;
   logic [PAIR_W-1:0] wr_pair;
   logic              rd_pop, rd_skip;
   logic [PAIR_W-1:0] rd_head, rd_next;
   logic [LVL_W-1:0]  rd_level;

   aux_rx_deser #(.W(SAMPLE_W)) u_deser (
      .bclk    (aux_bclk),
      .rst_n   (rst_n),
      .lrck    (aux_lrck),
      .data    (aux_data),
      .wr_en   (wr_en),
      .wr_pair (wr_pair)
   );

   aux_pair_fifo #(.DW(PAIR_W), .DEPTH(FIFO_DEPTH), .SYNC(2)) u_fifo (
      .wclk     (aux_bclk),
      .rclk     (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_pair),
      .rd_pop   (rd_pop),
      .rd_skip  (rd_skip),
      .rd_head  (rd_head),
      .rd_next  (rd_next),
      .rd_level (rd_level)
   );

   main_frame_tx #(
      .W(SAMPLE_W), .SLOT(MAIN_SLOT), .DEPTH(FIFO_DEPTH), .PRIME(PRIME_LEVEL)
   ) u_tx (
      .clk            (clk),
      .rst_n          (rst_n),
      .adc_left       (adc_left),
      .adc_right      (adc_right),
      .route_sel      (route_sel),
      .rd_head        (rd_head),
      .rd_next        (rd_next),
      .rd_level       (rd_level),
      .rd_pop         (rd_pop),
      .rd_skip        (rd_skip),
      .main_lrck      (main_lrck),
      .sdout1         (sdout1),
      .sdout2         (sdout2),
      .underflow_flag (underflow_flag),
      .overflow_flag  (overflow_flag)
   );
endmodule

// File: rtl/aux_audio_router_chk.sv
module aux_audio_router_chk #(
   parameter int W    = 20,
   parameter int SLOT = 32
) (
   input logic clk,
   input logic rst_n,
   input logic route_sel_unused,
   input logic main_lrck,
   input logic sdout1,
   input logic sdout2,
   input logic underflow_flag,
   input logic overflow_flag
);
   localparam int PW = $clog2(SLOT);

   logic [PW-1:0] pos;
   logic          exp_lrck;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos      <= '0;
         exp_lrck <= 1'b0;
      end else if (pos == PW'(SLOT - 1)) begin
         pos      <= '0;
         exp_lrck <= ~exp_lrck;
      end else begin
         pos <= pos + PW'(1);
      end
   end

   // R2: frame clock follows an independent slot counter
   p_lrck_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
      main_lrck == exp_lrck);

   // R3: bits beyond the sample in each slot are zero
   p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(pos) >= 32'(W)) |-> (!sdout1 && !sdout2));

   // R10: flags never clear without reset
   p_unf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      underflow_flag |=> underflow_flag);

   p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_flag |=> overflow_flag);

   // R2: frame clock changes only at slot boundaries
   p_lrck_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pos != '0) |-> $stable(main_lrck));

   wire unused_ok = route_sel_unused;
endmodule

bind aux_audio_router aux_audio_router_chk #(.W(SAMPLE_W), .SLOT(MAIN_SLOT)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .route_sel_unused (route_sel[0]),
   .main_lrck        (main_lrck),
   .sdout1           (sdout1),
   .sdout2           (sdout2),
   .underflow_flag   (underflow_flag),
   .overflow_flag    (overflow_flag)
);

// File: tb/tb_aux_audio_router.sv
`timescale 1ps/1ps
module tb_aux_audio_router;
   localparam int W    = 20;
   localparam int SLOT = 32;
   localparam logic [19:0] KEY = 20'h93C5A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic aux_bclk = 1'b0;
   logic aux_lrck = 1'b1;
   logic aux_data = 1'b0;
   logic [W-1:0] adc_left = '0, adc_right = '0;
   logic [1:0] route_sel = 2'd1;
   logic main_lrck, sdout1, sdout2, underflow_flag, overflow_flag;

   int n_chk = 0, n_fail = 0;
   int sent_last = -1;
   int aux_half = 2000;
   bit done = 1'b0;

   always #2000 clk = ~clk;
   initial begin
      #1300;
      forever #(aux_half) aux_bclk = ~aux_bclk;
   end

   aux_audio_router #(.SAMPLE_W(W), .MAIN_SLOT(SLOT), .FIFO_DEPTH(4), .PRIME_LEVEL(2)) dut (
      .clk(clk), .rst_n(rst_n), .aux_bclk(aux_bclk), .aux_lrck(aux_lrck), .aux_data(aux_data),
      .adc_left(adc_left), .adc_right(adc_right), .route_sel(route_sel),
      .main_lrck(main_lrck), .sdout1(sdout1), .sdout2(sdout2),
      .underflow_flag(underflow_flag), .overflow_flag(overflow_flag));

   function automatic logic [19:0] ax_l(input int n);
      return 20'(n) ^ KEY;
   endfunction
   function automatic logic [19:0] ax_r(input int n);
      return 20'(n * 37 + 'h40001);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // aux serial source: left slot low, 20 data bits then padding driven high (R1)
   initial begin
      @(posedge rst_n);
      for (int n = 0; ; n++) begin
         for (int b = 0; b < 64; b++) begin
            logic [19:0] smp;
            int s;
            @(negedge aux_bclk);
            s = b % 32;
            smp = (b < 32) ? ax_l(n) : ax_r(n);
            aux_lrck = (b >= 32);
            aux_data = (s < 20) ? smp[19 - s] : 1'b1;
            if (b == 51) sent_last = n;
         end
      end
   end

   task automatic get_frame(output logic [19:0] l1, output logic [19:0] r1,
                            output logic [19:0] l2, output logic [19:0] r2,
                            output bit pad_ok, output int snap);
      logic [63:0] w1, w2;
      logic p;
      p = main_lrck;
      @(negedge clk);
      while (main_lrck || !p) begin
         p = main_lrck;
         @(negedge clk);
      end
      snap = sent_last;
      for (int i = 0; i < 64; i++) begin
         if (i > 0) @(negedge clk);
         w1[63 - i] = sdout1;
         w2[63 - i] = sdout2;
      end
      l1 = w1[63:44]; r1 = w1[31:12];
      l2 = w2[63:44]; r2 = w2[31:12];
      pad_ok = (w1[43:32] == 0) && (w1[11:0] == 0) && (w2[43:32] == 0) && (w2[11:0] == 0);
   endtask

   task automatic adc_frames(input int cnt, input logic [19:0] el, input logic [19:0] er, input string tag);
      logic [19:0] l1, r1, l2, r2;
      bit pad;
      int snap;
      for (int k = 0; k < cnt; k++) begin
         get_frame(l1, r1, l2, r2, pad, snap);
         chk(l1 == el && r1 == er, {tag, " out1"}, {l1[15:0], r1[15:0]}, {el[15:0], er[15:0]});
         chk(l2 == el && r2 == er, {tag, " out2"}, {l2[15:0], r2[15:0]}, {el[15:0], er[15:0]});
         chk(pad, "R3 padding", 32'(pad), 32'd1);
      end
   endtask

   initial begin
      logic [19:0] l1, r1, l2, r2;
      bit pad;
      int snap, idx, prev, reps, skips;

      repeat (5) @(negedge clk);
      // R10: reset state
      chk(sdout1 == 0 && sdout2 == 0, "R10 reset outputs", {sdout1, sdout2}, 0);
      chk(!underflow_flag && !overflow_flag, "R10 reset flags", {underflow_flag, overflow_flag}, 0);
      chk(main_lrck == 0, "R2 reset lrck", main_lrck, 0);
      rst_n = 1'b1;

      // R7: before priming the aux pair is zero
      get_frame(l1, r1, l2, r2, pad, snap);
      chk(l1 == 0 && r1 == 0, "R7 unprimed zero", {l1[15:0], r1[15:0]}, 0);
      chk(l2 == 0 && r2 == 0, "R5 muted out2", {l2[15:0], r2[15:0]}, 0);

      // R4: converter to both outputs, select 0 then 3
      route_sel = 2'd0; adc_left = 20'h81234; adc_right = 20'h7FFFF;
      get_frame(l1, r1, l2, r2, pad, snap);
      adc_frames(3, 20'h81234, 20'h7FFFF, "R4 sel0");
      route_sel = 2'd3; adc_left = 20'h00001; adc_right = 20'hFFFFE;
      get_frame(l1, r1, l2, r2, pad, snap);
      adc_frames(2, 20'h00001, 20'hFFFFE, "R4 sel3");

      // R5, R7, R1: aux on out1, silence on out2, consecutive with bounded latency
      route_sel = 2'd1;
      get_frame(l1, r1, l2, r2, pad, snap);
      get_frame(l1, r1, l2, r2, pad, snap);
      prev = int'(l1 ^ KEY);
      for (int k = 0; k < 10; k++) begin
         get_frame(l1, r1, l2, r2, pad, snap);
         idx = int'(l1 ^ KEY);
         chk(r1 == ax_r(idx), "R1 aux right sample", r1, ax_r(idx));
         chk(idx == prev + 1, "R7 consecutive pair", idx, prev + 1);
         chk(snap - idx >= 1 && snap - idx <= 3, "R7 latency", snap - idx, 2);
         chk(l2 == 0 && r2 == 0, "R5 out2 silent", {l2[15:0], r2[15:0]}, 0);
         chk(pad, "R3 padding aux", 32'(pad), 32'd1);
         prev = idx;
      end

      // R6: aux on out1, converter on out2
      route_sel = 2'd2; adc_left = 20'hA5A5A; adc_right = 20'h0F0F0;
      get_frame(l1, r1, l2, r2, pad, snap);
      prev = int'(l1 ^ KEY);
      for (int k = 0; k < 5; k++) begin
         get_frame(l1, r1, l2, r2, pad, snap);
         idx = int'(l1 ^ KEY);
         chk(idx == prev + 1 && r1 == ax_r(idx), "R6 out1 aux", idx, prev + 1);
         chk(l2 == 20'hA5A5A && r2 == 20'h0F0F0, "R6 out2 adc", {l2[15:0], r2[15:0]}, 32'h5A5AF0F0);
         prev = idx;
      end
      chk(!underflow_flag, "R8 no underflow at equal rate", underflow_flag, 0);
      chk(!overflow_flag, "R9 no overflow at equal rate", overflow_flag, 0);

      // R8: slower aux source starves the buffer
      route_sel = 2'd1;
      aux_half = 2200;
      reps = 0;
      get_frame(l1, r1, l2, r2, pad, snap);
      prev = int'(l1 ^ KEY);
      for (int k = 0; k < 30; k++) begin
         get_frame(l1, r1, l2, r2, pad, snap);
         idx = int'(l1 ^ KEY);
         chk(idx == prev || idx == prev + 1, "R8 step while slow", idx - prev, 1);
         if (idx == prev) reps++;
         prev = idx;
      end
      chk(reps >= 1, "R8 pair repeated", reps, 1);
      chk(underflow_flag, "R8 underflow flag", underflow_flag, 1);
      chk(!overflow_flag, "R9 no overflow while slow", overflow_flag, 0);

      // R9: faster aux source overfills the buffer
      aux_half = 1800;
      skips = 0;
      get_frame(l1, r1, l2, r2, pad, snap);
      prev = int'(l1 ^ KEY);
      for (int k = 0; k < 60; k++) begin
         get_frame(l1, r1, l2, r2, pad, snap);
         idx = int'(l1 ^ KEY);
         chk(idx - prev >= 0 && idx - prev <= 2, "R9 step while fast", idx - prev, 1);
         if (idx == prev + 2) skips++;
         prev = idx;
      end
      chk(skips >= 1, "R9 oldest pair dropped", skips, 1);
      chk(overflow_flag, "R9 overflow flag", overflow_flag, 1);

      // R10: flags stay set after rates match again
      aux_half = 2000;
      for (int k = 0; k < 5; k++) get_frame(l1, r1, l2, r2, pad, snap);
      chk(underflow_flag && overflow_flag, "R10 sticky flags", {underflow_flag, overflow_flag}, 2'b11);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule